// File: doc/BRIEF.md
# Dual-Clock FIFO with Protocol Error Flags

This block moves 16-bit words from one clock domain to another when the two clocks have no fixed relationship. A producer pushes words with a write-enable in its own clock domain. A consumer sees the oldest stored word on its data output whenever the empty flag is low, and it pops that word with a read-enable in its own clock domain. Storage is a 16-entry register array that can be written and read at the same time.

Each side keeps a binary pointer five bits wide. The top bit is a wrap marker, and it is what tells a full queue from an empty one. Before a pointer leaves its home domain it is turned into Gray code. The other domain then samples it through two flops. Full is worked out on the write side and empty on the read side, each from the local pointer and the synchronized copy of the remote pointer.

Misuse of the queue is caught on the side where it happens. A push while full sets a sticky overflow flag, and a pop while empty sets a sticky underflow flag. Each domain also keeps a free-running count of the transfers it has accepted, so that the Nth word pushed can be matched against the Nth word popped.

Top module: `dcfifo_top`

## Requirements
- R1: After both resets, rdEmpty is 1, wrFull is 0, wrOverflow and rdUnderflow are 0, and wrCount and rdCount are 0.
- R2: Words appear on rdData in the order they were pushed and with the values they had when pushed. This holds both for bursts and for pushes interleaved with pops.
- R3: A push while wrFull is 1 is refused. It does not move the write pointer, does not change wrCount and does not change any stored word.
- R4: A pop while rdEmpty is 1 is refused. It does not move the read pointer, and the next word pushed is still the next word read.
- R5: wrOverflow goes to 1 in the write clock cycle after a push attempt while full. It then stays at 1 until the write-domain reset.
- R6: rdUnderflow goes to 1 in the read clock cycle after a pop attempt while empty. It then stays at 1 until the read-domain reset.
- R7: wrCount rises by exactly one for each accepted push, and rdCount rises by exactly one for each accepted pop.
- R8: With no pops, wrFull is 1 in the write clock cycle after the 16th accepted push. The queue then holds all 16 words.
- R9: The pointer copy that crosses each domain is Gray coded. It changes in at most one bit per clock of its source domain.
- R10: After reset the flag and count outputs are never unknown. rdData is known whenever a pop is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write domain clock |
| wrRstN | input | 1 | Write domain reset, active low, asynchronous |
| wrEn | input | 1 | Push request |
| wrData | input | DATA_W | Word to push |
| wrFull | output | 1 | Queue full as seen by the write domain |
| wrOverflow | output | 1 | Sticky flag for a push while full |
| wrCount | output | CNT_W | Accepted pushes since reset |
| rdClk | input | 1 | Read domain clock |
| rdRstN | input | 1 | Read domain reset, active low, asynchronous |
| rdEn | input | 1 | Pop request |
| rdData | output | DATA_W | Oldest stored word, valid while rdEmpty is 0 |
| rdEmpty | output | 1 | Queue empty as seen by the read domain |
| rdUnderflow | output | 1 | Sticky flag for a pop while empty |
| rdCount | output | CNT_W | Accepted pops since reset |

## Verification
Some rules are checked on every edge of the clock they belong to:
- a refused push or pop leaves its count and pointer unchanged;
- each sticky flag rises only after misuse and never falls before reset;
- each accepted transfer adds exactly one to its count;
- each crossing pointer changes in at most one bit;
- no status output is unknown.

Other behaviour needs the bench's scenarios, because it depends on history across both domains. This covers the order and values of the data, the cycle in which full rises, and the fact that a push refused while full leaves every stored word untouched.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef struct packed {
    logic              wrAccept;
    logic [ADDR_W-1:0] wrAddr;
    logic [ADDR_W-1:0] rdAddr;
  } ctrlStrobes_t;
endpackage

// File: rtl/dcfifo_sync.sv
module dcfifo_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/dcfifo_ctrl.sv
module dcfifo_ctrl
  import dcfifo_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                  wrClk,
  input  logic                  wrRstN,
  input  logic                  wrEn,
  output logic                  wrFull,
  output logic                  wrOverflow,
  output logic [CNT_W-1:0]      wrCount,
  output logic [ADDR_W:0]       wrGrayPtr,
  input  logic                  rdClk,
  input  logic                  rdRstN,
  input  logic                  rdEn,
  output logic                  rdEmpty,
  output logic                  rdUnderflow,
  output logic [CNT_W-1:0]      rdCount,
  output logic [ADDR_W:0]       rdGrayPtr,
  output ctrlStrobes_t          strobes
);
  localparam int PTR_W = ADDR_W + 1;

  logic [PTR_W-1:0] wrBin, wrBinNext, rdBin, rdBinNext;
  logic [PTR_W-1:0] rdGrayInWr, wrGrayInRd;
  logic             wrAccept, rdAccept;

  // write domain
  assign wrAccept  = wrEn & ~wrFull;
  assign wrBinNext = wrBin + {{(PTR_W-1){1'b0}}, wrAccept};
  assign wrFull    = (wrGrayPtr == {~rdGrayInWr[PTR_W-1:PTR_W-2], rdGrayInWr[PTR_W-3:0]});

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      wrBin      <= '0;
      wrGrayPtr  <= '0;
      wrCount    <= '0;
      wrOverflow <= 1'b0;
    end else begin
      wrBin     <= wrBinNext;
      wrGrayPtr <= wrBinNext ^ (wrBinNext >> 1);
      if (wrAccept)
        wrCount <= wrCount + 1'b1;
      if (wrEn && wrFull)
        wrOverflow <= 1'b1;
    end
  end

  // read domain
  assign rdAccept  = rdEn & ~rdEmpty;
  assign rdBinNext = rdBin + {{(PTR_W-1){1'b0}}, rdAccept};
  assign rdEmpty   = (rdGrayPtr == wrGrayInRd);

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rdBin       <= '0;
      rdGrayPtr   <= '0;
      rdCount     <= '0;
      rdUnderflow <= 1'b0;
    end else begin
      rdBin     <= rdBinNext;
      rdGrayPtr <= rdBinNext ^ (rdBinNext >> 1);
      if (rdAccept)
        rdCount <= rdCount + 1'b1;
      if (rdEn && rdEmpty)
        rdUnderflow <= 1'b1;
    end
  end

  dcfifo_sync #(.W(PTR_W)) syncRdToWr (
    .clk(wrClk), .rstN(wrRstN), .d(rdGrayPtr), .q(rdGrayInWr)
  );
  dcfifo_sync #(.W(PTR_W)) syncWrToRd (
    .clk(rdClk), .rstN(rdRstN), .d(wrGrayPtr), .q(wrGrayInRd)
  );

  assign strobes.wrAccept = wrAccept;
  assign strobes.wrAddr   = wrBin[ADDR_W-1:0];
  assign strobes.rdAddr   = rdBin[ADDR_W-1:0];
endmodule

// File: rtl/dcfifo_mem.sv
module dcfifo_mem
  import dcfifo_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              wrClk,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strobes.wrAccept)
      cells[strobes.wrAddr] <= wrData;
  end

  assign rdData = cells[strobes.rdAddr];
endmodule

// File: rtl/dcfifo_top.sv
module dcfifo_top
  import dcfifo_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              wrClk,
  input  logic              wrRstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrFull,
  output logic              wrOverflow,
  output logic [CNT_W-1:0]  wrCount,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdEmpty,
  output logic              rdUnderflow,
  output logic [CNT_W-1:0]  rdCount
);
  ctrlStrobes_t      strobes;
  logic [ADDR_W:0]   wrGrayPtr, rdGrayPtr;

  dcfifo_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrEn(wrEn), .wrFull(wrFull),
    .wrOverflow(wrOverflow), .wrCount(wrCount), .wrGrayPtr(wrGrayPtr),
    .rdClk(rdClk), .rdRstN(rdRstN), .rdEn(rdEn), .rdEmpty(rdEmpty),
    .rdUnderflow(rdUnderflow), .rdCount(rdCount), .rdGrayPtr(rdGrayPtr),
    .strobes(strobes)
  );

  dcfifo_mem #(.DATA_W(DATA_W)) mem_i (
    .wrClk(wrClk), .strobes(strobes), .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/dcfifo_chk.sv
module dcfifo_chk #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int PTR_W  = 5
) (
  input logic              wrClk,
  input logic              wrRstN,
  input logic              wrEn,
  input logic              wrFull,
  input logic              wrOverflow,
  input logic [CNT_W-1:0]  wrCount,
  input logic [PTR_W-1:0]  wrGrayPtr,
  input logic              rdClk,
  input logic              rdRstN,
  input logic              rdEn,
  input logic [DATA_W-1:0] rdData,
  input logic              rdEmpty,
  input logic              rdUnderflow,
  input logic [CNT_W-1:0]  rdCount,
  input logic [PTR_W-1:0]  rdGrayPtr
);
  p_refused_push_r3: assert property (@(posedge wrClk) disable iff (!wrRstN)
    (wrEn && wrFull) |=> ($stable(wrCount) && $stable(wrGrayPtr)));

  p_refused_pop_r4: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (rdEn && rdEmpty) |=> ($stable(rdCount) && $stable(rdGrayPtr)));

  p_ovf_sticky_r5: assert property (@(posedge wrClk) disable iff (!wrRstN)
    wrOverflow |=> wrOverflow);

  p_ovf_cause_r5: assert property (@(posedge wrClk) disable iff (!wrRstN)
    (!wrOverflow && !(wrEn && wrFull)) |=> !wrOverflow);

  p_udf_sticky_r6: assert property (@(posedge rdClk) disable iff (!rdRstN)
    rdUnderflow |=> rdUnderflow);

  p_udf_cause_r6: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (!rdUnderflow && !(rdEn && rdEmpty)) |=> !rdUnderflow);

  p_wr_count_r7: assert property (@(posedge wrClk) disable iff (!wrRstN)
    (wrEn && !wrFull) |=> (wrCount == $past(wrCount) + 1'b1));

  p_rd_count_r7: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (rdEn && !rdEmpty) |=> (rdCount == $past(rdCount) + 1'b1));

  p_wr_gray_r9: assert property (@(posedge wrClk) disable iff (!wrRstN)
    1'b1 |=> ($countones(wrGrayPtr ^ $past(wrGrayPtr)) <= 1));

  p_rd_gray_r9: assert property (@(posedge rdClk) disable iff (!rdRstN)
    1'b1 |=> ($countones(rdGrayPtr ^ $past(rdGrayPtr)) <= 1));

  p_wr_known_r10: assert property (@(posedge wrClk) disable iff (!wrRstN)
    !$isunknown({wrFull, wrOverflow, wrCount}));

  p_rd_known_r10: assert property (@(posedge rdClk) disable iff (!rdRstN)
    !$isunknown({rdEmpty, rdUnderflow, rdCount}));

  p_data_known_r10: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (rdEn && !rdEmpty) |-> !$isunknown(rdData));
endmodule

bind dcfifo_top dcfifo_chk #(
  .DATA_W(DATA_W), .CNT_W(CNT_W), .PTR_W(dcfifo_pkg::ADDR_W + 1)
) chk_i (
  .wrClk(wrClk), .wrRstN(wrRstN), .wrEn(wrEn), .wrFull(wrFull),
  .wrOverflow(wrOverflow), .wrCount(wrCount), .wrGrayPtr(wrGrayPtr),
  .rdClk(rdClk), .rdRstN(rdRstN), .rdEn(rdEn), .rdData(rdData),
  .rdEmpty(rdEmpty), .rdUnderflow(rdUnderflow), .rdCount(rdCount),
  .rdGrayPtr(rdGrayPtr)
);

// File: tb/dcfifo_tb.sv
`timescale 1ns/1ps
module dcfifo_top_tb_top;
  localparam int DW = 16;
  localparam int CW = 16;
  localparam int NVEC = 10;
  localparam logic [DW-1:0] VEC [NVEC] = '{
    16'h0001, 16'hFFFF, 16'h8000, 16'h5555, 16'hAAAA,
    16'h1234, 16'h0000, 16'hBEEF, 16'h7FFE, 16'hC3C3
  };

  logic wrClk = 1'b0, rdClk = 1'b0;
  logic wrRstN = 1'b0, rdRstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic wrFull, wrOverflow, rdEmpty, rdUnderflow;
  logic [CW-1:0] wrCount, rdCount;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 wrClk = ~wrClk;
  always #5.5 rdClk = ~rdClk;

  dcfifo_top #(.DATA_W(DW), .CNT_W(CW)) dut_i (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrEn(wrEn), .wrData(wrData),
    .wrFull(wrFull), .wrOverflow(wrOverflow), .wrCount(wrCount),
    .rdClk(rdClk), .rdRstN(rdRstN), .rdEn(rdEn), .rdData(rdData),
    .rdEmpty(rdEmpty), .rdUnderflow(rdUnderflow), .rdCount(rdCount)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [DW-1:0] d);
    @(negedge wrClk);
    wrEn = 1'b1;
    wrData = d;
    @(negedge wrClk);
    wrEn = 1'b0;
  endtask

  task automatic popCheck(input logic [DW-1:0] exp, input string req);
    @(negedge rdClk);
    while (rdEmpty) @(negedge rdClk);
    check(rdData === exp, req, 32'(rdData), 32'(exp));
    rdEn = 1'b1;
    @(negedge rdClk);
    rdEn = 1'b0;
  endtask

  task automatic settle();
    repeat (8) @(negedge rdClk);
  endtask

  initial begin
    repeat (100000) @(posedge wrClk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge rdClk);
    wrRstN = 1'b1;
    rdRstN = 1'b1;
    repeat (2) @(negedge wrClk);
    // R1 reset state
    check(rdEmpty === 1'b1, "R1 rdEmpty", 32'(rdEmpty), 1);
    check(wrFull === 1'b0, "R1 wrFull", 32'(wrFull), 0);
    check(wrOverflow === 1'b0 && rdUnderflow === 1'b0, "R1 flags",
          {30'd0, wrOverflow, rdUnderflow}, 0);
    check(wrCount === 0 && rdCount === 0, "R1 counts", {wrCount, rdCount}, 0);

    // R4 R6: pop while empty
    @(negedge rdClk);
    rdEn = 1'b1;
    @(negedge rdClk);
    rdEn = 1'b0;
    check(rdUnderflow === 1'b1, "R6 underflow set", 32'(rdUnderflow), 1);
    check(rdCount === 0, "R4 rdCount held", 32'(rdCount), 0);
    push(16'hA5A5);
    popCheck(16'hA5A5, "R4 first word after refused pop");

    // R2 burst from vector table
    for (int i = 0; i < NVEC; i++) push(VEC[i]);
    for (int i = 0; i < NVEC; i++) popCheck(VEC[i], "R2 burst order");

    // R2 interleaved
    for (int i = 0; i < 5; i++) begin
      push(16'h3C00 + 16'(i));
      popCheck(16'h3C00 + 16'(i), "R2 interleaved");
    end
    settle();
    check(wrCount === 16, "R7 wrCount", 32'(wrCount), 16);
    check(rdCount === 16, "R7 rdCount", 32'(rdCount), 16);
    check(rdEmpty === 1'b1, "R2 empty after drain", 32'(rdEmpty), 1);
    check(rdUnderflow === 1'b1, "R6 underflow sticky", 32'(rdUnderflow), 1);

    // R8 fill, R3 R5 overflow
    for (int i = 0; i < 15; i++) push(16'h0F0F ^ (16'h1111 * 16'(i)));
    check(wrFull === 1'b0, "R8 not full at 15", 32'(wrFull), 0);
    push(16'h0F0F ^ (16'h1111 * 16'd15));
    check(wrFull === 1'b1, "R8 full at 16", 32'(wrFull), 1);
    check(wrOverflow === 1'b0, "R5 no overflow yet", 32'(wrOverflow), 0);
    push(16'hDEAD);
    check(wrOverflow === 1'b1, "R5 overflow set", 32'(wrOverflow), 1);
    check(wrCount === 32, "R3 wrCount held", 32'(wrCount), 32);
    for (int i = 0; i < 16; i++)
      popCheck(16'h0F0F ^ (16'h1111 * 16'(i)), "R3 contents kept");
    settle();
    check(rdEmpty === 1'b1, "R3 refused word absent", 32'(rdEmpty), 1);
    check(rdCount === 32, "R7 rdCount after fill", 32'(rdCount), 32);
    check(wrOverflow === 1'b1, "R5 overflow sticky", 32'(wrOverflow), 1);

    // R1 reset clears sticky flags
    wrRstN = 1'b0;
    rdRstN = 1'b0;
    repeat (2) @(negedge rdClk);
    wrRstN = 1'b1;
    rdRstN = 1'b1;
    repeat (2) @(negedge wrClk);
    check(wrOverflow === 1'b0 && rdUnderflow === 1'b0, "R1 flags cleared",
          {30'd0, wrOverflow, rdUnderflow}, 0);
    check(wrCount === 0 && rdCount === 0 && rdEmpty === 1'b1, "R1 counts cleared",
          {wrCount, rdCount}, 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule